// File: doc/BRIEF.md
# IDE Bus-Master DMA Engine

This block moves sector data between an IDE drive and system memory without processor involvement. Software finds the register block through a base-address value (bit 0 set marks I/O space; the block decodes that value with its low four bits cleared). It stores the physical address of a descriptor table in memory, picks a direction and sets the run bit. The engine then fetches 8-byte descriptors one after another. Each descriptor names a memory region and its byte count. The engine streams that region one 16-bit word at a time between the drive data handshake and a memory master port.

When the region whose descriptor carries the end-of-table flag has been fully moved, the engine drops its active flag and raises a sticky interrupt flag, which drives the interrupt pin. Software acknowledges by reading the status register and writing the same value back. A memory fault reported on the master port stops the engine and raises both the error and interrupt flags. Clearing the run bit during a transfer stops it silently. No memory cycle is issued while the bus-master enable input is low.

Top module: `ide_bm_dma`

## Requirements
- R1: An I/O access hits the block only when io_addr[15:4] equals io_bar[15:4]. The command register sits at offset 0, status at offset 2 and the table pointer at offset 4. Read data appears on io_rdata one cycle after io_rd. A read that misses returns 0, and a write that misses changes nothing.
- R2: The table pointer is 32 bits wide. Its bits 1:0 always read 0, whatever was written.
- R3: Status bits 5 and 6 are software read/write capability bits and reset to 0. Status bit 0 reads 1 while a transfer is active. After reset the status reads 0x00; right after a start with bit 5 set it reads 0x21.
- R4: Status bit 1 (error) and bit 2 (interrupt) clear when a 1 is written to them. Writing back the value just read therefore clears them and leaves bits 5 and 6 unchanged.
- R5: A write to the command register that takes bit 0 from 0 to 1 while idle starts the engine. Bit 3 of that write selects the direction: 0 moves drive data into memory, 1 moves memory data to the drive.
- R6: Each descriptor is read as four 16-bit memory reads at pointer+0, +2, +4 and +6. Word 0 is address bits 15:0, word 1 is address bits 31:16, word 2 is the byte count, and bit 15 of word 3 is the end-of-table flag. The following descriptor starts at pointer+8.
- R7: A region moves count/2 words in order, at consecutive even addresses starting at the region address. A count of 0 means 65536 bytes.
- R8: After the last word of the end-of-table region, the active bit clears and the interrupt bit sets in the same cycle. The irq output follows the interrupt bit.
- R9: The engine never raises mem_req unless bm_enable was high in the previous cycle. While bm_enable is low, pending work waits.
- R10: Writing the command register with bit 0 clear during a transfer aborts it. Active clears, the interrupt bit stays 0, and no further memory or drive handshakes occur.
- R11: A mem_err reported together with mem_ack stops the transfer and sets status bits 1 and 2.
- R12: mem_req, mem_addr and mem_we hold steady until mem_ack (unless the transfer stops). drv_ack is a one-cycle pulse per word moved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bm_enable | input | 1 | Bus-master enable from configuration space |
| io_bar | input | 16 | Base-address value for the register block |
| io_addr | input | 16 | I/O access address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 32 | I/O write data |
| io_rdata | output | 32 | I/O read data, one cycle after io_rd |
| mem_req | output | 1 | Memory access request, held until mem_ack |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address (even) |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory access completes this cycle |
| mem_err | input | 1 | Memory access failed, valid with mem_ack |
| drv_req | input | 1 | Drive is ready to supply or accept a word |
| drv_ack | output | 1 | One-cycle word handshake to the drive |
| drv_rdata | input | 16 | Word from the drive |
| drv_wdata | output | 16 | Word to the drive, valid with drv_ack |
| irq | output | 1 | Interrupt, follows status bit 2 |

## Verification
On every cycle the assertions check the memory and drive handshakes. A pending request must stay unchanged until it is acknowledged. No request may start without the bus-master enable. drv_ack must be a single-cycle pulse. Nothing may move while the engine is idle, and the interrupt may rise only when the active flag falls. The bench's scenarios are what show the data itself: the descriptor walk, the word order and addresses in each direction, the 64 KiB meaning of a zero count, and the register semantics. Those semantics cover base decoding, pointer alignment, write-one-to-clear, abort without an interrupt and the error path.

// File: rtl/ide_bm_pkg.sv
package ide_bm_pkg;
  localparam logic [3:0] OFS_CMD  = 4'h0;
  localparam logic [3:0] OFS_STAT = 4'h2;
  localparam logic [3:0] OFS_PTR  = 4'h4;

  localparam int CMD_RUN = 0;
  localparam int CMD_M2D = 3;

  localparam int ST_ACT  = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_IRQ  = 2;
  localparam int ST_CAP0 = 5;
  localparam int ST_CAP1 = 6;

  typedef enum logic [1:0] {
    E_IDLE,
    E_DESC,
    E_DRV,
    E_MEM
  } eng_state_t;
endpackage

// File: rtl/ide_bm_regs.sv
module ide_bm_regs
  import ide_bm_pkg::*;
#(
  parameter int IO_AW   = 16,
  parameter int DEC_LSB = 4,
  parameter int PA_W    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IO_AW-1:0] io_bar,
  input  logic [IO_AW-1:0] io_addr,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic [PA_W-1:0]  io_wdata,
  output logic [PA_W-1:0]  io_rdata,
  input  logic             busy,
  input  logic             done_evt,
  input  logic             err_evt,
  output logic             start_req,
  output logic             stop_req,
  output logic             start_m2d,
  output logic [PA_W-1:0]  tbl_ptr,
  output logic             stat_irq
);
  logic [DEC_LSB-1:0] ofs;
  logic               hit, wr_cmd, wr_stat, wr_ptr;
  logic               cmd_run, cmd_dir, stat_err;
  logic [1:0]         stat_cap;
  logic [7:0]         stat_byte;
  logic               unused_bits;

  assign unused_bits = ^io_bar[DEC_LSB-1:0];
  assign hit     = io_addr[IO_AW-1:DEC_LSB] == io_bar[IO_AW-1:DEC_LSB];
  assign ofs     = io_addr[DEC_LSB-1:0];
  assign wr_cmd  = io_wr && hit && (ofs == DEC_LSB'(OFS_CMD));
  assign wr_stat = io_wr && hit && (ofs == DEC_LSB'(OFS_STAT));
  assign wr_ptr  = io_wr && hit && (ofs == DEC_LSB'(OFS_PTR));

  assign start_req = wr_cmd && io_wdata[CMD_RUN] && !cmd_run && !busy;
  assign stop_req  = wr_cmd && !io_wdata[CMD_RUN] && busy;
  assign start_m2d = io_wdata[CMD_M2D];

  assign stat_byte = {1'b0, stat_cap[1], stat_cap[0], 2'b00, stat_irq, stat_err, busy};

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_run  <= 1'b0;
      cmd_dir  <= 1'b0;
      stat_cap <= 2'b00;
      stat_err <= 1'b0;
      stat_irq <= 1'b0;
      tbl_ptr  <= '0;
      io_rdata <= '0;
    end else begin
      if (wr_cmd) begin
        cmd_run <= io_wdata[CMD_RUN];
        if (!busy) cmd_dir <= io_wdata[CMD_M2D];
      end
      if (wr_stat) stat_cap <= {io_wdata[ST_CAP1], io_wdata[ST_CAP0]};
      stat_err <= err_evt || (stat_err && !(wr_stat && io_wdata[ST_ERR]));
      stat_irq <= done_evt || err_evt || (stat_irq && !(wr_stat && io_wdata[ST_IRQ]));
      if (wr_ptr) tbl_ptr <= {io_wdata[PA_W-1:2], 2'b00};
      io_rdata <= '0;
      if (io_rd && hit) begin
        if (ofs == DEC_LSB'(OFS_CMD))
          io_rdata <= PA_W'({cmd_dir, 2'b00, cmd_run});
        else if (ofs == DEC_LSB'(OFS_STAT))
          io_rdata <= PA_W'(stat_byte);
        else if (ofs == DEC_LSB'(OFS_PTR))
          io_rdata <= tbl_ptr;
      end
    end
  end
endmodule

// File: rtl/ide_bm_engine.sv
module ide_bm_engine
  import ide_bm_pkg::*;
#(
  parameter int PA_W = 32,
  parameter int DW   = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start_req,
  input  logic            stop_req,
  input  logic            start_m2d,
  input  logic [PA_W-1:0] tbl_ptr,
  input  logic            bm_enable,
  output logic            busy,
  output logic            done_evt,
  output logic            err_evt,
  output logic            mem_req,
  output logic            mem_we,
  output logic [PA_W-1:0] mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_ack,
  input  logic            mem_err,
  input  logic            drv_req,
  output logic            drv_ack,
  input  logic [DW-1:0]   drv_rdata,
  output logic [DW-1:0]   drv_wdata
);
  localparam logic [DW-1:0] ZERO_WORDS = DW'(1) << (DW - 1);
  localparam logic [DW-1:0] ONE_WORD   = DW'(1);
  localparam logic [PA_W-1:0] DESC_BYTES = PA_W'(8);
  localparam logic [PA_W-1:0] WORD_BYTES = PA_W'(2);

  eng_state_t      state;
  logic            m2d, eot;
  logic [1:0]      didx;
  logic [PA_W-1:0] dptr, raddr;
  logic [DW-1:0]   wleft, cnt_r, hold;
  logic            mem_ok, word_done;
  eng_state_t      data_state;

  assign mem_ok     = mem_req && mem_ack && !mem_err;
  assign data_state = m2d ? E_MEM : E_DRV;
  assign word_done  = !stop_req &&
                      ((state == E_MEM && mem_ok && !m2d) ||
                       (state == E_DRV && drv_req && m2d));
  assign done_evt   = word_done && (wleft == ONE_WORD) && eot;
  assign err_evt    = !stop_req && mem_req && mem_ack && mem_err && (state != E_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= E_IDLE;
      busy      <= 1'b0;
      m2d       <= 1'b0;
      eot       <= 1'b0;
      didx      <= '0;
      dptr      <= '0;
      raddr     <= '0;
      wleft     <= '0;
      cnt_r     <= '0;
      hold      <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      drv_ack   <= 1'b0;
      drv_wdata <= '0;
    end else begin
      drv_ack <= 1'b0;
      if (stop_req) begin
        state   <= E_IDLE;
        busy    <= 1'b0;
        mem_req <= 1'b0;
      end else begin
        case (state)
          E_IDLE: begin
            if (start_req) begin
              busy  <= 1'b1;
              m2d   <= start_m2d;
              dptr  <= tbl_ptr;
              didx  <= '0;
              state <= E_DESC;
            end
          end
          E_DESC: begin
            if (!mem_req) begin
              if (bm_enable) begin
                mem_req  <= 1'b1;
                mem_we   <= 1'b0;
                mem_addr <= dptr + PA_W'({didx, 1'b0});
              end
            end else if (mem_ack) begin
              mem_req <= 1'b0;
              if (mem_err) begin
                state <= E_IDLE;
                busy  <= 1'b0;
              end else begin
                didx <= didx + 2'd1;
                case (didx)
                  2'd0: raddr[DW-1:0]    <= mem_rdata;
                  2'd1: raddr[PA_W-1:DW] <= mem_rdata;
                  2'd2: cnt_r            <= mem_rdata;
                  default: begin
                    eot   <= mem_rdata[DW-1];
                    wleft <= (cnt_r == '0) ? ZERO_WORDS : {1'b0, cnt_r[DW-1:1]};
                    dptr  <= dptr + DESC_BYTES;
                    state <= data_state;
                  end
                endcase
              end
            end
          end
          E_DRV: begin
            if (drv_req) begin
              drv_ack <= 1'b1;
              if (!m2d) begin
                hold  <= drv_rdata;
                state <= E_MEM;
              end
            end
          end
          default: begin
            if (!mem_req) begin
              if (bm_enable) begin
                mem_req   <= 1'b1;
                mem_we    <= !m2d;
                mem_addr  <= raddr;
                mem_wdata <= hold;
              end
            end else if (mem_ack) begin
              mem_req <= 1'b0;
              if (mem_err) begin
                state <= E_IDLE;
                busy  <= 1'b0;
              end else if (m2d) begin
                drv_wdata <= mem_rdata;
                state     <= E_DRV;
              end
            end
          end
        endcase
        if (word_done) begin
          raddr <= raddr + WORD_BYTES;
          wleft <= wleft - ONE_WORD;
          if (wleft == ONE_WORD) begin
            if (eot) begin
              state <= E_IDLE;
              busy  <= 1'b0;
            end else begin
              state <= E_DESC;
              didx  <= '0;
            end
          end else begin
            state <= data_state;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ide_bm_dma.sv
module ide_bm_dma
  import ide_bm_pkg::*;
#(
  parameter int IO_AW   = 16,
  parameter int DEC_LSB = 4,
  parameter int PA_W    = 32,
  parameter int DW      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bm_enable,
  input  logic [IO_AW-1:0] io_bar,
  input  logic [IO_AW-1:0] io_addr,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic [PA_W-1:0]  io_wdata,
  output logic [PA_W-1:0]  io_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [PA_W-1:0]  mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_ack,
  input  logic             mem_err,
  input  logic             drv_req,
  output logic             drv_ack,
  input  logic [DW-1:0]    drv_rdata,
  output logic [DW-1:0]    drv_wdata,
  output logic             irq
);
  logic            eng_busy, done_evt, err_evt;
  logic            start_req, stop_req, start_m2d;
  logic [PA_W-1:0] tbl_ptr;

  ide_bm_regs #(.IO_AW(IO_AW), .DEC_LSB(DEC_LSB), .PA_W(PA_W)) i_regs (
    .clk       (clk),
    .rst       (rst),
    .io_bar    (io_bar),
    .io_addr   (io_addr),
    .io_wr     (io_wr),
    .io_rd     (io_rd),
    .io_wdata  (io_wdata),
    .io_rdata  (io_rdata),
    .busy      (eng_busy),
    .done_evt  (done_evt),
    .err_evt   (err_evt),
    .start_req (start_req),
    .stop_req  (stop_req),
    .start_m2d (start_m2d),
    .tbl_ptr   (tbl_ptr),
    .stat_irq  (irq)
  );

  ide_bm_engine #(.PA_W(PA_W), .DW(DW)) i_engine (
    .clk       (clk),
    .rst       (rst),
    .start_req (start_req),
    .stop_req  (stop_req),
    .start_m2d (start_m2d),
    .tbl_ptr   (tbl_ptr),
    .bm_enable (bm_enable),
    .busy      (eng_busy),
    .done_evt  (done_evt),
    .err_evt   (err_evt),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_ack   (mem_ack),
    .mem_err   (mem_err),
    .drv_req   (drv_req),
    .drv_ack   (drv_ack),
    .drv_rdata (drv_rdata),
    .drv_wdata (drv_wdata)
  );
endmodule

// File: rtl/ide_bm_dma_chk.sv
module ide_bm_dma_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            busy,
  input logic            bm_enable,
  input logic            mem_req,
  input logic            mem_ack,
  input logic            mem_we,
  input logic [PA_W-1:0] mem_addr,
  input logic            drv_ack,
  input logic            irq
);
  // R12: a waiting memory request keeps its address and kind until acknowledged
  a_r12_mem_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> ((mem_req && $stable(mem_addr) && $stable(mem_we)) || !busy));

  // R9: a new memory request needs the bus-master enable one cycle earlier
  a_r9_bm_gate: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> $past(bm_enable));

  // R12: drive acknowledge lasts a single cycle
  a_r12_drv_pulse: assert property (@(posedge clk) disable iff (rst)
    drv_ack |=> !drv_ack);

  // R8: the interrupt rises only together with the end of activity
  a_r8_irq_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $fell(busy));

  // R10: an engine idle for two cycles makes no handshakes
  a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> (!mem_req && !drv_ack));
endmodule

bind ide_bm_dma ide_bm_dma_chk #(.PA_W(PA_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (eng_busy),
  .bm_enable (bm_enable),
  .mem_req   (mem_req),
  .mem_ack   (mem_ack),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .drv_ack   (drv_ack),
  .irq       (irq)
);

// File: tb/test_ide_bm_dma.sv
`timescale 1ns/1ps
module test_ide_bm_dma;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bm_enable = 1'b1;
  logic [15:0] io_bar = 16'hC001;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = '0;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic        drv_req = 1'b0;
  logic        drv_ack;
  logic [15:0] drv_rdata = '0;
  logic [15:0] drv_wdata;
  logic        irq;

  int vectors = 0;
  int miscompares = 0;
  int acc_count = 0;
  int drv_taken = 0;
  bit err_arm = 0;
  bit m2d_mode = 0;
  bit drv_on = 0;
  bit req_q = 0, bm_q = 1;

  logic [15:0] mem [0:4095];
  logic [31:0] exp_addr[$];
  bit          exp_we[$];
  logic [15:0] exp_data[$];
  logic [15:0] drv_src[$];
  logic [15:0] drv_exp[$];

  always #2 clk = ~clk;

  ide_bm_dma i_ide_bm_dma (
    .clk(clk), .rst(rst), .bm_enable(bm_enable), .io_bar(io_bar),
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
    .io_rdata(io_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack), .mem_err(mem_err), .drv_req(drv_req),
    .drv_ack(drv_ack), .drv_rdata(drv_rdata), .drv_wdata(drv_wdata),
    .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory slave model: one-cycle acknowledge, compared against expected accesses
  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
      mem_err = 1'b0;
    end else if (mem_req) begin
      acc_count++;
      if (exp_addr.size() == 0) begin
        check("R6 unexpected memory access", mem_addr, 32'hFFFF_FFFF);
      end else begin
        check("R6 R7 access address", mem_addr, exp_addr[0]);
        check("R5 access direction", {31'b0, mem_we}, {31'b0, exp_we[0]});
        if (exp_we[0]) check("R7 written word", {16'b0, mem_wdata}, {16'b0, exp_data[0]});
        void'(exp_addr.pop_front());
        void'(exp_we.pop_front());
        void'(exp_data.pop_front());
      end
      if (mem_we) mem[mem_addr[12:1]] = mem_wdata;
      mem_rdata = mem[mem_addr[12:1]];
      mem_err = err_arm;
      err_arm = 0;
      mem_ack = 1'b1;
    end
    if (!rst && mem_req && !req_q && !bm_q)
      check("R9 request without enable", 32'd1, 32'd0);
    req_q = mem_req;
    bm_q = bm_enable;
  end

  // drive model
  always @(negedge clk) begin
    if (!rst && drv_ack) begin
      drv_taken++;
      if (m2d_mode) begin
        if (drv_exp.size() != 0) check("R7 word to drive", {16'b0, drv_wdata}, {16'b0, drv_exp.pop_front()});
        else check("R12 surplus drive handshake", 32'd1, 32'd0);
      end else if (drv_src.size() != 0) begin
        void'(drv_src.pop_front());
      end
    end
    drv_req = drv_on && (m2d_mode ? (drv_exp.size() != 0) : (drv_src.size() != 0));
    drv_rdata = (drv_src.size() != 0) ? drv_src[0] : 16'h0;
  end

  task automatic io_write(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    io_rd = 1'b1; io_addr = a;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic put_desc(input logic [31:0] p, input logic [31:0] a, input logic [15:0] c, input bit last);
    mem[p[12:1]]       = a[15:0];
    mem[p[12:1] + 1]   = a[31:16];
    mem[p[12:1] + 2]   = c;
    mem[p[12:1] + 3]   = {last, 15'h0};
    for (int k = 0; k < 4; k++) begin
      exp_addr.push_back(p + 32'(2 * k)); exp_we.push_back(1'b0); exp_data.push_back(16'h0);
    end
  endtask

  task automatic exp_acc(input logic [31:0] a, input bit we, input logic [15:0] d);
    exp_addr.push_back(a); exp_we.push_back(we); exp_data.push_back(d);
  endtask

  task automatic wait_irq(input string req);
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      if (irq) return;
    end
    check(req, {31'b0, irq}, 32'd1);
  endtask

  task automatic start(input bit dir_m2d);
    io_write(16'hC000, {28'h0, dir_m2d, 3'b000});
    io_write(16'hC000, {28'h0, dir_m2d, 3'b001});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check("R8 watchdog timeout", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int snap_acc, snap_drv;
    for (int k = 0; k < 4096; k++) mem[k] = 16'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    check("R8 irq after reset", {31'b0, irq}, 32'd0);
    check("R12 no request after reset", {31'b0, mem_req}, 32'd0);
    io_read(16'hC002, rd); check("R3 status after reset", rd, 32'h00);
    io_read(16'hC004, rd); check("R2 pointer after reset", rd, 32'h0);

    // decoding and plain bits
    io_write(16'hC002, 32'h20);
    io_read(16'hC002, rd); check("R3 capability bit", rd, 32'h20);
    io_write(16'hD002, 32'h40);
    io_read(16'hC002, rd); check("R1 foreign write ignored", rd, 32'h20);
    io_read(16'hD002, rd); check("R1 foreign read is zero", rd, 32'h0);
    io_write(16'hC004, 32'h0000_0103);
    io_read(16'hC004, rd); check("R2 pointer alignment", rd, 32'h100);

    // drive to memory, one region
    put_desc(32'h100, 32'h400, 16'd8, 1'b1);
    for (int k = 0; k < 4; k++) begin
      drv_src.push_back(16'hA001 + 16'(k));
      exp_acc(32'h400 + 32'(2 * k), 1'b1, 16'hA001 + 16'(k));
    end
    m2d_mode = 0; drv_on = 1; snap_drv = drv_taken;
    start(1'b0);
    io_read(16'hC002, rd); check("R3 status while active", rd, 32'h21);
    wait_irq("R8 completion interrupt");
    @(negedge clk);
    io_read(16'hC002, rd); check("R8 status after completion", rd, 32'h24);
    check("R6 all accesses made", exp_addr.size(), 32'd0);
    check("R7 memory contents", {16'b0, mem[12'h203]}, 32'hA004);
    check("R12 one drive pulse per word", drv_taken - snap_drv, 32'd4);
    io_write(16'hC002, rd);
    io_read(16'hC002, rd); check("R4 write-back clears flags", rd, 32'h20);
    check("R8 irq follows flag", {31'b0, irq}, 32'd0);

    // memory to drive, two regions
    io_write(16'hC004, 32'h200);
    put_desc(32'h200, 32'h600, 16'd4, 1'b0);
    for (int k = 0; k < 2; k++) begin
      mem[12'h300 + 12'(k)] = 16'hB001 + 16'(k);
      drv_exp.push_back(16'hB001 + 16'(k));
      exp_acc(32'h600 + 32'(2 * k), 1'b0, 16'h0);
    end
    put_desc(32'h208, 32'h700, 16'd6, 1'b1);
    for (int k = 0; k < 3; k++) begin
      mem[12'h380 + 12'(k)] = 16'hB003 + 16'(k);
      drv_exp.push_back(16'hB003 + 16'(k));
      exp_acc(32'h700 + 32'(2 * k), 1'b0, 16'h0);
    end
    m2d_mode = 1;
    start(1'b1);
    wait_irq("R8 completion after chained regions");
    @(negedge clk);
    check("R5 all drive words delivered", drv_exp.size(), 32'd0);
    check("R6 second descriptor walked", exp_addr.size(), 32'd0);
    io_read(16'hC002, rd); check("R8 status after chain", rd, 32'h24);
    io_write(16'hC002, rd);

    // bus-master enable gating
    bm_enable = 1'b0;
    m2d_mode = 0;
    io_write(16'hC004, 32'h300);
    put_desc(32'h300, 32'h800, 16'd4, 1'b1);
    for (int k = 0; k < 2; k++) begin
      drv_src.push_back(16'hC001 + 16'(k));
      exp_acc(32'h800 + 32'(2 * k), 1'b1, 16'hC001 + 16'(k));
    end
    snap_acc = acc_count;
    start(1'b0);
    repeat (40) @(negedge clk);
    check("R9 no access while disabled", acc_count - snap_acc, 32'd0);
    io_read(16'hC002, rd); check("R9 still active while disabled", rd, 32'h21);
    bm_enable = 1'b1;
    wait_irq("R9 completion after enable");
    @(negedge clk);
    check("R9 accesses after enable", exp_addr.size(), 32'd0);
    io_read(16'hC002, rd);
    io_write(16'hC002, rd);

    // zero count means 64 KiB, then abort
    io_write(16'hC004, 32'h380);
    put_desc(32'h380, 32'h1000, 16'd0, 1'b1);
    for (int k = 0; k < 300; k++) begin
      drv_src.push_back(16'hD000 + 16'(k));
      exp_acc(32'h1000 + 32'(2 * k), 1'b1, 16'hD000 + 16'(k));
    end
    start(1'b0);
    for (int n = 0; n < 5000 && drv_src.size() > 40; n++) @(negedge clk);
    io_read(16'hC002, rd); check("R7 zero count still active", rd, 32'h21);
    io_write(16'hC000, 32'h0);
    @(negedge clk);
    snap_acc = acc_count; snap_drv = drv_taken;
    repeat (20) @(negedge clk);
    check("R10 no memory access after abort", acc_count - snap_acc, 32'd0);
    check("R10 no drive pulse after abort", drv_taken - snap_drv, 32'd0);
    io_read(16'hC002, rd); check("R10 status after abort", rd, 32'h20);
    check("R10 no interrupt on abort", {31'b0, irq}, 32'd0);
    drv_src.delete(); exp_addr.delete(); exp_we.delete(); exp_data.delete();
    @(negedge clk);

    // memory error
    io_write(16'hC004, 32'h3C0);
    mem[12'h1E0] = 16'h0;
    exp_acc(32'h3C0, 1'b0, 16'h0);
    err_arm = 1;
    start(1'b0);
    wait_irq("R11 interrupt on error");
    @(negedge clk);
    io_read(16'hC002, rd); check("R11 status after error", rd, 32'h26);
    io_write(16'hC002, rd);
    io_read(16'hC002, rd); check("R4 error flag cleared", rd, 32'h20);
    check("R4 irq low after clear", {31'b0, irq}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule